// File: doc/BRIEF.md
# Fuse Array Access Sequencer

This block sits between a host and a one-time-programmable fuse array built from 32-bit words. The host asks for a run of consecutive words to be read or burned. The block then drives the array's control pins through a fixed order: wake-up, trim, enable, mode, clock or write strobe, and release. Every hold time comes from a nanosecond parameter, converted to clock cycles through a clock-frequency parameter. All phases are timed by a single down-counter, and the state machine steps only when that counter is zero.

Read data comes back one word per `rd_valid` strobe. When burning, the block asks for each new word with a one-cycle `wr_ready` strobe and captures `wr_data` on the next rising edge. It then shifts the word out one bit per write strobe. It does this twice: first into the main cells with the spare select low, then into the spare cells with it high. A request that reaches past the configured array size is refused with an `err` pulse, and no pin moves.

Top module: `fuse_seq`

## Requirements
- R1: A request with `req_index >= TOTAL_FUSES` or `req_index + req_count > TOTAL_FUSES` gives a one-cycle `err` pulse. `busy` stays low and no array pin changes.
- R2: A read raises `fz_wake`, then `fz_trim_en`, then `fz_en`, one cycle apart, before the first rise of `fz_clk`.
- R3: For each read word, in ascending index order, `fz_addr` holds the word index while `fz_clk` is high for tCD cycles. `rd_valid` and `rd_data` (equal to `fz_dout`) appear tKL cycles after `fz_clk` falls. There is exactly one `rd_valid` per requested word.
- R4: A read ends by dropping `fz_en`, then `fz_trim_en`, then `fz_wake`, and never touches `fz_pgm`, `fz_mode` or `fz_wr`.
- R5: A burn raises `fz_wake`, then `fz_trim_en`, then sets `fz_mode` to 2 with all other array pins at zero. It raises `fz_en` tMS cycles after that, and then raises `fz_pgm`. `fz_mode` is 2 whenever `fz_wr` is high.
- R6: Each burned word gets exactly one `wr_ready` strobe, followed by 64 write strobes. Strobe k (k = 0..63) has `fz_addr` = the word index, `fz_spare` = k/32, `fz_bit` = k mod 32, and `fz_din` = bit (k mod 32) of the word.
- R7: `fz_addr`, `fz_spare`, `fz_bit` and `fz_din` are stable for at least tASP cycles before `fz_wr` rises. `fz_wr` is high for exactly tPW cycles. It stays low for at least tPWI + tASP cycles between strobes.
- R8: After each burned word `fz_spare` returns to 0. A burn ends by dropping `fz_wr`, `fz_pgm`, `fz_en`, `fz_mode`, `fz_trim_en` and `fz_wake`, in that order.
- R9: `busy` rises the cycle after a request is accepted and stays high through the release of `fz_wake`. `done` is a one-cycle pulse one cycle after `fz_wake` falls, in the same cycle in which `busy` drops.
- R10: A `start` while `busy` is high has no effect: no extra word, strobe or error, and no second run.
- R11: Out of reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken while idle |
| req_op | input | 1 | 0 read, 1 burn |
| req_index | input | IDX_W | First word index |
| req_count | input | IDX_W+1 | Number of words |
| wr_data | input | DATA_W | Burn word, captured the edge after `wr_ready` |
| wr_ready | output | 1 | Next burn word wanted |
| rd_valid | output | 1 | `rd_data` holds a read word |
| rd_data | output | DATA_W | Read word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| err | output | 1 | Request refused pulse |
| fz_wake | output | 1 | Standby release, high = awake |
| fz_trim_en | output | 1 | Trim enable |
| fz_en | output | 1 | Array enable |
| fz_pgm | output | 1 | Program enable |
| fz_mode | output | 2 | Test mode pins |
| fz_clk | output | 1 | Array read clock |
| fz_addr | output | IDX_W | Word address |
| fz_bit | output | log2(DATA_W) | Bit address |
| fz_spare | output | 1 | Spare cell select |
| fz_din | output | 1 | Burn data bit |
| fz_wr | output | 1 | Write strobe |
| fz_dout | input | DATA_W | Array read data |

## Verification
The assertions assume that the host holds `wr_data` valid at the edge after `wr_ready`. They also assume that `fz_dout` is settled by the end of the clock-low phase. The bench meets both assumptions. It loads `wr_data` at the falling edge on which it first sees `wr_ready`. It drives `fz_dout` combinationally from `fz_addr` through a fixed pattern, so the data is steady long before it is sampled. Requests are swept over every start index and count just past a six-word array, so both kinds of range refusal are reached. A stray `start` is sent only while a run is in progress.

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int TOTAL_FUSES = 4096,
  parameter int DATA_W      = 32,
  parameter int CLK_MHZ     = 250,
  parameter int TCD_NS      = 40000,
  parameter int TKL_NS      = 10000,
  parameter int TMS_NS      = 1000,
  parameter int TASP_NS     = 1000,
  parameter int TPW_NS      = 20000,
  parameter int TPWI_NS     = 5000,
  localparam int IDX_W = (TOTAL_FUSES > 1) ? $clog2(TOTAL_FUSES) : 1,
  localparam int CNT_W = IDX_W + 1,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_op,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              fz_wake,
  output logic              fz_trim_en,
  output logic              fz_en,
  output logic              fz_pgm,
  output logic [1:0]        fz_mode,
  output logic              fz_clk,
  output logic [IDX_W-1:0]  fz_addr,
  output logic [BIT_W-1:0]  fz_bit,
  output logic              fz_spare,
  output logic              fz_din,
  output logic              fz_wr,
  input  logic [DATA_W-1:0] fz_dout
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam logic [31:0] W_CD   = 32'(to_cyc(TCD_NS) - 1);
  localparam logic [31:0] W_KL   = 32'(to_cyc(TKL_NS) - 1);
  localparam logic [31:0] W_MS   = 32'(to_cyc(TMS_NS) - 1);
  localparam logic [31:0] W_ASP  = 32'(to_cyc(TASP_NS) - 1);
  localparam logic [31:0] W_PW   = 32'(to_cyc(TPW_NS) - 1);
  localparam logic [31:0] W_PWI  = 32'(to_cyc(TPWI_NS) - 1);
  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(TOTAL_FUSES);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  typedef enum logic [4:0] {
    S_IDLE, S_WAKE, S_TRIM, S_MODE, S_EN, S_PGM, S_WORD,
    S_CLKH, S_CLKL, S_SAMP, S_CAP, S_WRH, S_WRL, S_STEP,
    S_XWR, S_XPGM, S_XEN, S_XMODE, S_XTRIM, S_XWAKE, S_FIN
  } st_t;

  st_t               st;
  logic [31:0]       tmr;
  logic              op;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  rem;
  logic [DATA_W-1:0] word;
  logic              refuse;

  assign refuse = ({2'b00, req_index} >= LIMIT) ||
                  (({2'b00, req_index} + {1'b0, req_count}) > LIMIT);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; op <= 1'b0; idx <= '0; rem <= '0; word <= '0;
      wr_ready <= 1'b0; rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; err <= 1'b0;
      fz_wake <= 1'b0; fz_trim_en <= 1'b0; fz_en <= 1'b0; fz_pgm <= 1'b0;
      fz_mode <= 2'd0; fz_clk <= 1'b0; fz_addr <= '0; fz_bit <= '0;
      fz_spare <= 1'b0; fz_din <= 1'b0; fz_wr <= 1'b0;
    end else begin
      wr_ready <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (tmr != 32'd0) begin
        tmr <= tmr - 32'd1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            if (refuse) err <= 1'b1;
            else begin
              op <= req_op; idx <= req_index; rem <= req_count; st <= S_WAKE;
            end
          end
          S_WAKE: begin fz_wake <= 1'b1; st <= S_TRIM; end
          S_TRIM: begin fz_trim_en <= 1'b1; st <= op ? S_MODE : S_EN; end
          S_MODE: begin
            fz_clk <= 1'b0; fz_addr <= '0; fz_spare <= 1'b0; fz_bit <= '0;
            fz_din <= 1'b0; fz_wr <= 1'b0; fz_mode <= 2'd2;
            tmr <= W_MS; st <= S_EN;
          end
          S_EN:  begin fz_en <= 1'b1; st <= op ? S_PGM : S_WORD; end
          S_PGM: begin fz_pgm <= 1'b1; st <= S_WORD; end
          S_WORD: begin
            if (rem == '0) st <= op ? S_XWR : S_XEN;
            else begin
              fz_addr <= idx;
              if (op) begin wr_ready <= 1'b1; st <= S_CAP; end
              else st <= S_CLKH;
            end
          end
          S_CLKH: begin fz_clk <= 1'b1; tmr <= W_CD; st <= S_CLKL; end
          S_CLKL: begin fz_clk <= 1'b0; tmr <= W_KL; st <= S_SAMP; end
          S_SAMP: begin
            rd_data <= fz_dout; rd_valid <= 1'b1;
            idx <= idx + IDX_W'(1); rem <= rem - CNT_W'(1); st <= S_WORD;
          end
          S_CAP: begin
            word <= wr_data; fz_spare <= 1'b0; fz_bit <= '0; fz_din <= wr_data[0];
            tmr <= W_ASP; st <= S_WRH;
          end
          S_WRH: begin fz_wr <= 1'b1; tmr <= W_PW; st <= S_WRL; end
          S_WRL: begin fz_wr <= 1'b0; tmr <= W_PWI; st <= S_STEP; end
          S_STEP: begin
            if (fz_bit != LAST_BIT) begin
              fz_bit <= fz_bit + BIT_W'(1);
              fz_din <= word[fz_bit + BIT_W'(1)];
              tmr <= W_ASP; st <= S_WRH;
            end else if (!fz_spare) begin
              fz_spare <= 1'b1; fz_bit <= '0; fz_din <= word[0];
              tmr <= W_ASP; st <= S_WRH;
            end else begin
              fz_spare <= 1'b0;
              idx <= idx + IDX_W'(1); rem <= rem - CNT_W'(1); st <= S_WORD;
            end
          end
          S_XWR:   begin fz_wr <= 1'b0; st <= S_XPGM; end
          S_XPGM:  begin fz_pgm <= 1'b0; st <= S_XEN; end
          S_XEN:   begin fz_en <= 1'b0; st <= op ? S_XMODE : S_XTRIM; end
          S_XMODE: begin fz_mode <= 2'd0; st <= S_XTRIM; end
          S_XTRIM: begin fz_trim_en <= 1'b0; st <= S_XWAKE; end
          S_XWAKE: begin fz_wake <= 1'b0; st <= S_FIN; end
          S_FIN:   begin done <= 1'b1; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_strobe_in_burn_mode: assert property (@(posedge clk) disable iff (!rst_n)
    fz_wr |-> (fz_pgm && fz_en && fz_mode == 2'd2));
  a_r3_clock_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    fz_clk |-> (fz_en && !fz_pgm));
  a_r2_enable_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    fz_en |-> (fz_trim_en && fz_wake));
  a_r9_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fz_wake) |=> done);
  a_r1_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !fz_wake));
  a_r6_ready_between_words: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!fz_wr && fz_pgm && !fz_spare));
  a_r3_sample_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!fz_clk && fz_en));
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/fuse_seq_test.sv
module fuse_seq_test;
  localparam int TOT = 6;
  localparam int MHZ = 1;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int T_CD  = (40000 * MHZ + 999) / 1000;
  localparam int T_KL  = (10000 * MHZ + 999) / 1000;
  localparam int T_MS  = (1000 * MHZ + 999) / 1000;
  localparam int T_ASP = (1000 * MHZ + 999) / 1000;
  localparam int T_PW  = (20000 * MHZ + 999) / 1000;
  localparam int T_PWI = (5000 * MHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0, req_op = 1'b0;
  logic [IW-1:0] req_index = '0;
  logic [CW-1:0] req_count = '0;
  logic [31:0] wr_data = '0;
  logic wr_ready, rd_valid, busy, done, err;
  logic [31:0] rd_data, fz_dout;
  logic fz_wake, fz_trim_en, fz_en, fz_pgm, fz_clk, fz_spare, fz_din, fz_wr;
  logic [1:0] fz_mode;
  logic [IW-1:0] fz_addr;
  logic [4:0] fz_bit;

  fuse_seq #(.TOTAL_FUSES(TOT), .CLK_MHZ(MHZ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_op(req_op), .req_index(req_index),
    .req_count(req_count), .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .done(done), .err(err), .fz_wake(fz_wake),
    .fz_trim_en(fz_trim_en), .fz_en(fz_en), .fz_pgm(fz_pgm), .fz_mode(fz_mode),
    .fz_clk(fz_clk), .fz_addr(fz_addr), .fz_bit(fz_bit), .fz_spare(fz_spare),
    .fz_din(fz_din), .fz_wr(fz_wr), .fz_dout(fz_dout));

  function automatic logic [31:0] rpat(int a);
    return 32'h5A3C_0F00 ^ (32'(a) * 32'h0101_0107);
  endfunction
  function automatic logic [31:0] wpat(int a);
    return 32'hC001_D00D ^ (32'(a) * 32'h1357_9BDF);
  endfunction

  assign fz_dout = rpat(int'(fz_addr));

  int total = 0, bad = 0;
  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cyc = 0, op_start = 0, rd_n = 0, np = 0, nready = 0, drv_n = 0;
  int nerr = 0, nwake = 0, nbusy = 0;
  int wake_r, wake_f, trim_r, trim_f, en_r, en_f, pgm_r, pgm_f, mode_r, mode_f;
  int clk_r, clk_f, wr_r, wr_f, first_clk, first_wr, done_c, lastchg = 0;
  logic p_wake = 0, p_trim = 0, p_en = 0, p_pgm = 0, p_mode = 0, p_clk = 0, p_wr = 0;
  logic [IW+6:0] p_sig = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ({fz_addr, fz_spare, fz_bit, fz_din} != p_sig) lastchg = cyc;
      if (fz_wake && !p_wake) begin wake_r = cyc; nwake++; end
      if (!fz_wake && p_wake) wake_f = cyc;
      if (fz_trim_en && !p_trim) trim_r = cyc;
      if (!fz_trim_en && p_trim) trim_f = cyc;
      if (fz_en && !p_en) en_r = cyc;
      if (!fz_en && p_en) en_f = cyc;
      if (fz_pgm && !p_pgm) pgm_r = cyc;
      if (!fz_pgm && p_pgm) pgm_f = cyc;
      if ((fz_mode != 2'd0) && !p_mode) mode_r = cyc;
      if ((fz_mode == 2'd0) && p_mode) mode_f = cyc;
      if (fz_clk && !p_clk) begin
        clk_r = cyc;
        if (first_clk < 0) first_clk = cyc;
        chk(int'(fz_addr) == op_start + rd_n, "R3 read address", fz_addr, op_start + rd_n);
      end
      if (!fz_clk && p_clk) begin
        clk_f = cyc;
        chk(cyc - clk_r == T_CD, "R3 clock high width", cyc - clk_r, T_CD);
      end
      if (rd_valid) begin
        chk(rd_data == rpat(op_start + rd_n), "R3 read data", rd_data, rpat(op_start + rd_n));
        chk(cyc - clk_f == T_KL, "R3 sample after low phase", cyc - clk_f, T_KL);
        rd_n++;
      end
      if (fz_wr && !p_wr) begin
        automatic int k = np % 64;
        automatic int w = op_start + np / 64;
        automatic logic [31:0] wv = wpat(w);
        chk(int'(fz_addr) == w, "R6 burn address", fz_addr, w);
        chk(int'(fz_spare) == k / 32, "R6 spare pass", fz_spare, k / 32);
        chk(int'(fz_bit) == k % 32, "R6 bit address", fz_bit, k % 32);
        chk(fz_din == wv[k % 32], "R6 data bit", fz_din, wv[k % 32]);
        chk(fz_mode == 2'd2, "R5 mode value", fz_mode, 2);
        chk(cyc - lastchg >= T_ASP, "R7 setup before strobe", cyc - lastchg, T_ASP);
        if (np > 0) chk(cyc - wr_f >= T_PWI + T_ASP, "R7 strobe interval", cyc - wr_f, T_PWI + T_ASP);
        if (first_wr < 0) first_wr = cyc;
        wr_r = cyc;
        np++;
      end
      if (!fz_wr && p_wr) begin
        chk(cyc - wr_r == T_PW, "R7 strobe width", cyc - wr_r, T_PW);
        wr_f = cyc;
      end
      if (wr_ready) nready++;
      if (err) nerr++;
      if (busy) nbusy++;
      if (done) done_c = cyc;
    end
    p_wake = fz_wake; p_trim = fz_trim_en; p_en = fz_en; p_pgm = fz_pgm;
    p_mode = (fz_mode != 2'd0); p_clk = fz_clk; p_wr = fz_wr;
    p_sig = {fz_addr, fz_spare, fz_bit, fz_din};
  end

  always @(negedge clk) begin
    if (wr_ready) begin
      wr_data = wpat(op_start + drv_n);
      drv_n++;
    end
  end

  task automatic clear_mon(int s);
    op_start = s; rd_n = 0; np = 0; nready = 0; drv_n = 0; nerr = 0; nwake = 0; nbusy = 0;
    wake_r = -1; wake_f = -1; trim_r = -1; trim_f = -1; en_r = -1; en_f = -1;
    pgm_r = -1; pgm_f = -1; mode_r = -1; mode_f = -1; clk_r = -1; clk_f = -1;
    wr_r = -1; wr_f = -1; first_clk = -1; first_wr = -1; done_c = -1;
  endtask

  task automatic issue(bit op, int s, int c);
    @(negedge clk);
    clear_mon(s);
    req_op = op; req_index = IW'(s); req_count = CW'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    ok = done;
    @(negedge clk);
  endtask

  task automatic finish_checks(int c);
    chk(done_c == wake_f + 1, "R9 done one cycle after release", done_c, wake_f + 1);
    chk(nbusy == done_c - wake_r + 1, "R9 busy span", nbusy, done_c - wake_r + 1);
    chk(nwake == 1 && nerr == 0, "R9 single run no error", nwake, 1);
  endtask

  task automatic run_read(int s, int c);
    bit ok;
    issue(1'b0, s, c);
    wait_done(ok);
    chk(ok, "R9 read completes", ok, 1);
    chk(rd_n == c, "R3 word count", rd_n, c);
    chk(trim_r == wake_r + 1 && en_r == trim_r + 1, "R2 entry order", en_r - wake_r, 2);
    if (c > 0) chk(first_clk > en_r, "R2 clock after enable", first_clk, en_r + 1);
    chk(wake_r > 0 && en_f < trim_f && trim_f < wake_f, "R4 exit order", wake_f - en_f, 2);
    chk(pgm_r < 0 && mode_r < 0 && np == 0, "R4 no burn pins", np, 0);
    finish_checks(c);
  endtask

  task automatic run_burn(int s, int c);
    bit ok;
    issue(1'b1, s, c);
    wait_done(ok);
    chk(ok, "R9 burn completes", ok, 1);
    chk(np == 64 * c, "R6 strobe count", np, 64 * c);
    chk(nready == c, "R6 ready count", nready, c);
    chk(trim_r == wake_r + 1 && mode_r > trim_r, "R5 wake trim mode order", mode_r - wake_r, 2);
    chk(en_r - mode_r == T_MS, "R5 mode setup time", en_r - mode_r, T_MS);
    chk(pgm_r > en_r && first_wr > pgm_r, "R5 program enable order", pgm_r - en_r, 1);
    chk(first_clk < 0, "R5 no read clock", first_clk, -1);
    chk(wr_f < pgm_f && pgm_f < en_f && en_f < mode_f && mode_f < trim_f && trim_f < wake_f,
        "R8 exit order", wake_f - wr_f, 6);
    chk(fz_spare == 1'b0, "R8 spare cleared", fz_spare, 0);
    finish_checks(c);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({wr_ready, rd_valid, busy, done, err, fz_wake, fz_trim_en, fz_en, fz_pgm, fz_clk,
         fz_spare, fz_din, fz_wr} == '0 && rd_data == '0 && fz_mode == '0 && fz_addr == '0 &&
         fz_bit == '0, "R11 reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        if (s >= TOT || s + c > TOT) begin
          issue(1'b0, s, c);
          repeat (3) @(negedge clk);
          chk(nerr == 1, "R1 refusal flagged", nerr, 1);
          chk(nwake == 0 && nbusy == 0 && first_clk < 0, "R1 no pin activity", nwake + nbusy, 0);
        end else begin
          run_read(s, c);
        end
      end
    end

    issue(1'b1, 5, 2);
    repeat (3) @(negedge clk);
    chk(nerr == 1 && np == 0 && nwake == 0, "R1 burn refused", nerr, 1);

    run_burn(0, 1);
    run_burn(4, 2);

    begin
      bit ok;
      issue(1'b0, 1, 2);
      repeat (5) @(negedge clk);
      req_op = 1'b1; req_index = '0; req_count = CW'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk(ok && rd_n == 2 && np == 0 && nready == 0 && nerr == 0,
          "R10 start while busy ignored", rd_n, 2);
      repeat (4) @(negedge clk);
      chk(!busy && nwake == 1, "R10 no second run", nwake, 1);
    end

    summary();
    $finish;
  end
endmodule